// File: doc/BRIEF.md
# PHY Register Handshake Master

This block lets on-chip logic read and write 16-bit registers inside a PHY that has no memory map of its own. The PHY is reached through one 20-bit control word and one 17-bit status word. Every step of a transaction is a four-phase exchange: the master raises a strobe, waits for the PHY acknowledge to go high, drops the strobe and waits for the acknowledge to go low. On the user side, a single-cycle request carries an address, a write flag and write data. A transaction ends in a one-cycle `done` pulse, with read data for reads, or in a one-cycle `err` pulse when an acknowledge wait runs out of polls.

The control word holds the address or data in bits [15:0]. Bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. The status word gives the acknowledge in bit 16 and read data in bits [15:0]. The acknowledge passes through a two-flop synchronizer before it is compared.

The controller is one state machine.
- From IDLE, an accepted request goes to ADDR_SET, which drives the address with no strobe for one cycle.
- ADDR_CAP adds the address-capture strobe and waits for ack high. ADDR_REL keeps the address, drops the strobe and waits for ack low.
- A write continues through DATA_SET (data only, one cycle), DATA_CAP (data plus data-capture strobe, waits for ack high), DATA_REL (data only, waits for ack low), WR_STB (write strobe alone, waits for ack high) and WR_REL (data only, waits for ack low).
- A read continues through RD_STB (read strobe alone, waits for ack high, latches the read data) and RD_REL (all zeros, waits for ack low).
- Both paths end in DONE, which drives all zeros and pulses `done`. Any wait that runs out of polls goes to FAIL, which drives all zeros and pulses `err`.
- DONE and FAIL both return to IDLE.

Top module: `phy_hs_master`

## Requirements
- R1: After reset, `phy_ctrl` is all zeros and `busy`, `done` and `err` are low.
- R2: Every transaction starts with the address phase. The control word shows the address alone, then the address with bit 16 set until ack is seen high, then the address alone until ack is seen low.
- R3: A write then drives this exact sequence of control values: data alone; data with bit 17; data alone; bit 18 alone; data alone; all zeros. Afterwards the PHY register at the given address holds the data.
- R4: A read then drives bit 19 alone and, when ack is seen high, latches status bits [15:0] into `rdata`. It then drives all zeros until ack is seen low. `rdata` does not change while the block is not busy.
- R5: Each acknowledge wait compares the synchronized ack once every POLL_CYCLES cycles (CLK_MHZ × POLL_US), for at most MAX_POLLS comparisons. An acknowledge that arrives inside this window lets the transaction complete normally.
- R6: When a wait for ack high exhausts its polls, `err` pulses for one cycle and `done` stays low. This happens between MAX_POLLS×POLL_CYCLES and MAX_POLLS×POLL_CYCLES+3 cycles after the request is accepted, and `phy_ctrl` returns to all zeros.
- R7: A wait for ack low that exhausts its polls also aborts with an `err` pulse and an all-zero control word.
- R8: A request is accepted only in IDLE. A request raised while `busy` is high has no effect on the PHY registers, and `busy` stays high from acceptance until the DONE or FAIL cycle.
- R9: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| rdata | output | 16 | Data returned by the last read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY (bit 16 ack) |

## Verification
The hardest cases to reach are the timeout paths, especially a release wait that never sees ack low: a well-behaved PHY never holds its acknowledge high. The bench's PHY responder has a programmable acknowledge delay, a mode that never acknowledges and a mode that holds the acknowledge high once raised. These reach both abort paths and the edges of the poll window. A second request is also injected in the middle of a write to show that it is dropped.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;
    localparam int DATA_W   = 16;
    localparam int CTRL_W   = 20;
    localparam int STAT_W   = 17;
    localparam int BIT_ACAP = 16;
    localparam int BIT_DCAP = 17;
    localparam int BIT_WSTB = 18;
    localparam int BIT_RSTB = 19;
    localparam int BIT_ACK  = 16;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR_SET, S_ADDR_CAP, S_ADDR_REL,
        S_DATA_SET, S_DATA_CAP, S_DATA_REL, S_WR_STB, S_WR_REL,
        S_RD_STB, S_RD_REL, S_DONE, S_FAIL
    } hs_state_e;
endpackage

// File: rtl/phy_hs_ack_sync.sv
module phy_hs_ack_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_out
);
    logic [1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= 2'b00;
        else        stage <= {stage[0], ack_in};
    end

    assign ack_out = stage[1];
endmodule

// File: rtl/phy_hs_poll_timer.sv
module phy_hs_poll_timer #(
    parameter int POLL_CYCLES = 100,
    parameter int MAX_POLLS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic check,
    output logic last
);
    localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] TICK_END = TW'(POLL_CYCLES - 1);
    localparam logic [PW-1:0] POLL_END = PW'(MAX_POLLS - 1);

    logic [TW-1:0] tick;
    logic [PW-1:0] polls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick  <= '0;
            polls <= '0;
        end else if (!run || restart) begin
            tick  <= '0;
            polls <= '0;
        end else if (tick == TICK_END) begin
            tick  <= '0;
            polls <= polls + 1'b1;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    assign check = run && (tick == TICK_END);
    assign last  = (polls == POLL_END);

    // R5: the poll count never passes its bound
    a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        polls < PW'(MAX_POLLS));
endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
    import phy_hs_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int POLL_US   = 1,
    parameter int MAX_POLLS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [DATA_W-1:0]    rdata,
    output logic [CTRL_W-1:0]    phy_ctrl,
    input  logic [STAT_W-1:0]    phy_stat
);
    localparam int POLL_CYCLES = CLK_MHZ * POLL_US;

    hs_state_e          state, state_n;
    logic [DATA_W-1:0]  addr_q, data_q;
    logic               wr_q;
    logic               ack_s, check, last;
    logic               waiting, want_ack;

    phy_hs_ack_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ack_in(phy_stat[BIT_ACK]), .ack_out(ack_s)
    );

    phy_hs_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(waiting),
        .restart(state_n != state), .check(check), .last(last)
    );

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            data_q <= '0;
            wr_q   <= 1'b0;
            rdata  <= '0;
        end else begin
            state <= state_n;
            if (state == S_IDLE && req_valid) begin
                addr_q <= req_addr;
                data_q <= req_wdata;
                wr_q   <= req_write;
            end
            if (state == S_RD_STB && check && ack_s)
                rdata <= phy_stat[DATA_W-1:0];
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (waiting && check && (ack_s != want_ack) && last) begin
            state_n = S_FAIL;
        end else begin
            unique case (state)
                S_IDLE:     if (req_valid) state_n = S_ADDR_SET;
                S_ADDR_SET: state_n = S_ADDR_CAP;
                S_ADDR_CAP: if (check && ack_s)  state_n = S_ADDR_REL;
                S_ADDR_REL: if (check && !ack_s) state_n = wr_q ? S_DATA_SET : S_RD_STB;
                S_DATA_SET: state_n = S_DATA_CAP;
                S_DATA_CAP: if (check && ack_s)  state_n = S_DATA_REL;
                S_DATA_REL: if (check && !ack_s) state_n = S_WR_STB;
                S_WR_STB:   if (check && ack_s)  state_n = S_WR_REL;
                S_WR_REL:   if (check && !ack_s) state_n = S_DONE;
                S_RD_STB:   if (check && ack_s)  state_n = S_RD_REL;
                S_RD_REL:   if (check && !ack_s) state_n = S_DONE;
                S_DONE:     state_n = S_IDLE;
                S_FAIL:     state_n = S_IDLE;
                default:    state_n = S_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        phy_ctrl = '0;
        waiting  = 1'b0;
        want_ack = 1'b0;
        unique case (state)
            S_ADDR_SET: phy_ctrl = {4'b0000, addr_q};
            S_ADDR_CAP: begin
                phy_ctrl = {4'b0000, addr_q};
                phy_ctrl[BIT_ACAP] = 1'b1;
                waiting = 1'b1; want_ack = 1'b1;
            end
            S_ADDR_REL: begin phy_ctrl = {4'b0000, addr_q}; waiting = 1'b1; end
            S_DATA_SET: phy_ctrl = {4'b0000, data_q};
            S_DATA_CAP: begin
                phy_ctrl = {4'b0000, data_q};
                phy_ctrl[BIT_DCAP] = 1'b1;
                waiting = 1'b1; want_ack = 1'b1;
            end
            S_DATA_REL: begin phy_ctrl = {4'b0000, data_q}; waiting = 1'b1; end
            S_WR_STB: begin
                phy_ctrl[BIT_WSTB] = 1'b1;
                waiting = 1'b1; want_ack = 1'b1;
            end
            S_WR_REL: begin phy_ctrl = {4'b0000, data_q}; waiting = 1'b1; end
            S_RD_STB: begin
                phy_ctrl[BIT_RSTB] = 1'b1;
                waiting = 1'b1; want_ack = 1'b1;
            end
            S_RD_REL: waiting = 1'b1;
            default:  phy_ctrl = '0;
        endcase
    end

    assign busy = (state != S_IDLE) && (state != S_DONE) && (state != S_FAIL);
    assign done = (state == S_DONE);
    assign err  = (state == S_FAIL);

    // R9: completion and timeout never coincide
    a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: at most one strobe bit on the control word
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phy_ctrl[BIT_RSTB:BIT_ACAP]) <= 1);
    // R8: a request while busy leaves the captured address alone
    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(addr_q));
    // R4: read data is held while the block is not busy
    a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rdata));
    // R6: after a timeout the control word is back at zero
    a_r6_err_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (phy_ctrl == '0));
endmodule

// File: tb/phy_hs_master_test.sv
module phy_hs_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_MHZ      = 4;
    localparam int T_POLLS    = 10;
    localparam int WIN        = T_MHZ * T_POLLS;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_addr = 0, req_wdata = 0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_hs_master #(.CLK_MHZ(T_MHZ), .POLL_US(1), .MAX_POLLS(T_POLLS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // PHY responder model
    int          ack_delay = 0;
    bit          never_ack = 0, hold_hi = 0;
    logic [15:0] mem [16];
    logic [15:0] a_reg, d_reg;
    logic [19:0] prev_ctrl;
    logic        lvl_q, ack_r;
    int          cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            a_reg <= '0; d_reg <= '0; prev_ctrl <= '0;
            lvl_q <= 1'b0; ack_r <= 1'b0; cnt <= 0;
        end else begin
            prev_ctrl <= phy_ctrl;
            if (phy_ctrl[16] && !prev_ctrl[16]) a_reg <= phy_ctrl[15:0];
            if (phy_ctrl[17] && !prev_ctrl[17]) d_reg <= phy_ctrl[15:0];
            if (phy_ctrl[18] && !prev_ctrl[18]) mem[a_reg[3:0]] <= d_reg;
            if ((|phy_ctrl[19:16]) != lvl_q) begin
                lvl_q <= |phy_ctrl[19:16];
                cnt   <= 0;
            end else if (cnt < ack_delay) begin
                cnt <= cnt + 1;
            end
            if (never_ack)               ack_r <= 1'b0;
            else if (hold_hi && ack_r)   ack_r <= 1'b1;
            else if (cnt >= ack_delay)   ack_r <= lvl_q;
        end
    end

    assign phy_stat = {ack_r, mem[a_reg[3:0]]};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [19:0] seq [16];
    int          nseq;
    int          t_cyc;
    logic        t_done, t_err, t_busy0;

    task automatic run_txn(input logic wr, input logic [15:0] a, input logic [15:0] d,
                           input bit intrude);
        logic [19:0] last_c;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        nseq = 0; last_c = '0; t_cyc = 0; t_done = 0; t_err = 0; t_busy0 = busy;
        while (t_cyc < 2000) begin
            if (phy_ctrl != last_c) begin
                if (nseq < 16) seq[nseq] = phy_ctrl;
                nseq++;
                last_c = phy_ctrl;
            end
            if (done) begin t_done = 1; break; end
            if (err)  begin t_err = 1;  break; end
            if (intrude && t_cyc == 5) begin
                req_valid = 1; req_write = 1; req_addr = 16'h0005; req_wdata = 16'h2222;
            end
            if (intrude && t_cyc == 6) req_valid = 0;
            @(negedge clk);
            t_cyc++;
        end
    endtask

    // stimulus table: {write, addr, data/expected}
    localparam int NV = 8;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 16'h0001, 16'h1234},
        {1'b1, 16'h0002, 16'hABCD},
        {1'b1, 16'h000F, 16'hFFFF},
        {1'b0, 16'h0001, 16'h1234},
        {1'b0, 16'h0002, 16'hABCD},
        {1'b0, 16'h000F, 16'hFFFF},
        {1'b1, 16'h0001, 16'h0000},
        {1'b0, 16'h0001, 16'h0000}
    };

    localparam logic [19:0] WSEQ [9] = '{
        20'h00003, 20'h10003, 20'h00003, 20'h05A5A, 20'h25A5A,
        20'h05A5A, 20'h40000, 20'h05A5A, 20'h00000
    };
    localparam logic [19:0] RSEQ [5] = '{
        20'h00003, 20'h10003, 20'h00003, 20'h80000, 20'h00000
    };

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(phy_ctrl == 0 && !busy && !done && !err, "R1 reset outputs",
              {phy_ctrl, busy, done, err}, 0);
        rst_n = 1;
        @(negedge clk);

        // table walk: R3 writes, R4 reads
        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][32], VEC[i][31:16], VEC[i][15:0], 0);
            check(t_done && !t_err, VEC[i][32] ? "R3 write completes" : "R4 read completes",
                  {t_done, t_err}, 2);
            if (!VEC[i][32])
                check(rdata == VEC[i][15:0], "R4 read data", rdata, VEC[i][15:0]);
        end

        // R2/R3: exact control sequence of a write
        run_txn(1, 16'h0003, 16'h5A5A, 0);
        check(nseq == 9, "R3 write step count", nseq, 9);
        for (int k = 0; k < 9; k++)
            check(seq[k] == WSEQ[k], k < 3 ? "R2 address phase" : "R3 write phase",
                  seq[k], WSEQ[k]);

        // R2/R4: exact control sequence of a read
        run_txn(0, 16'h0003, 16'h0000, 0);
        check(nseq == 5, "R4 read step count", nseq, 5);
        for (int k = 0; k < 5; k++)
            check(seq[k] == RSEQ[k], k < 3 ? "R2 address phase" : "R4 read phase",
                  seq[k], RSEQ[k]);
        check(rdata == 16'h5A5A, "R4 read back", rdata, 16'h5A5A);

        // R8: request while busy is dropped
        run_txn(1, 16'h0004, 16'h1111, 1);
        check(t_busy0, "R8 busy after accept", t_busy0, 1);
        check(t_done, "R8 first write done", t_done, 1);
        run_txn(0, 16'h0005, 16'h0000, 0);
        check(rdata == 16'h0000, "R8 intruding write ignored", rdata, 0);
        run_txn(0, 16'h0004, 16'h0000, 0);
        check(rdata == 16'h1111, "R8 original write kept", rdata, 16'h1111);

        // R5: late acknowledge inside the poll window
        ack_delay = 25;
        run_txn(1, 16'h0006, 16'h7777, 0);
        check(t_done && !t_err, "R5 late ack write", {t_done, t_err}, 2);
        run_txn(0, 16'h0006, 16'h0000, 0);
        check(t_done && rdata == 16'h7777, "R5 late ack read", rdata, 16'h7777);

        // R6: acknowledge later than the window times out
        ack_delay = 45;
        run_txn(0, 16'h0006, 16'h0000, 0);
        check(t_err && !t_done, "R6 slow ack times out", {t_done, t_err}, 1);
        ack_delay = 0;
        repeat (60) @(negedge clk);

        // R6: no acknowledge at all, timing and control zero
        never_ack = 1;
        run_txn(0, 16'h0007, 16'h0000, 0);
        check(t_err && !t_done, "R6 timeout err", {t_done, t_err}, 1);
        check(t_cyc >= WIN && t_cyc <= WIN + 3, "R6 timeout window", t_cyc, WIN);
        check(phy_ctrl == 0, "R6 ctrl zero on err", phy_ctrl, 0);
        @(negedge clk);
        check(!err && !busy && phy_ctrl == 0, "R9 err single pulse",
              {err, busy, phy_ctrl}, 0);
        never_ack = 0;
        repeat (5) @(negedge clk);

        // R7: acknowledge stuck high, release wait times out
        hold_hi = 1;
        run_txn(1, 16'h0008, 16'h0101, 0);
        check(t_err && !t_done, "R7 release wait timeout", {t_done, t_err}, 1);
        check(phy_ctrl == 0, "R7 ctrl zero on err", phy_ctrl, 0);
        hold_hi = 0;
        repeat (10) @(negedge clk);

        // recovery after aborts
        run_txn(1, 16'h0009, 16'h4242, 0);
        run_txn(0, 16'h0009, 16'h0000, 0);
        check(t_done && rdata == 16'h4242, "R4 recovery read", rdata, 16'h4242);
        @(negedge clk);
        check(!done, "R9 done single pulse", done, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule